// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block is the power-management state machine of a small processor subsystem. A one-cycle sleep request from the core puts the subsystem into one of two low-power states. A standby-select bit picks which one. A light sleep stops only the core clock. A deep software standby halts the clock generator, the core and every peripheral, and puts external memory into self-refresh. Each state has its own set of wake events. A deep standby that is left passes through a programmable settling wait before the core clock returns.

An active-low hardware-standby pin overrides everything and halts the subsystem at once. Once that state is entered, it can be left only through a power-on reset. The block also holds a stop bit and an extra-division bit for each peripheral module. These let software halt or slow single modules while the core keeps running. A small write port loads the control bits. The real dividers, the oscillator and the analog switching lie outside the block. They follow the enables it drives.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: While `por_n` is low and afterwards until an event occurs, `state_o` is 0 (run). `core_clk_en`, `periph_clk_en` and `cpg_en` are 1, `pin_hiz` is 0, `refresh_mode` is 0 (normal refresh), every `mod_clk_en` bit is 1 and every `mod_div_sel` bit is 0.
- R2: A `sleep_req` sampled in run with control bit 0 clear enters sleep on that edge. Control bit 0 is written with `wr_sel`=0, `wr_data[0]`. In sleep, `state_o`=1, `core_clk_en`=0, `periph_clk_en`=1, `cpg_en`=1 and `refresh_mode`=0.
- R3: In sleep, a sampled `irq`, `nmi` or `dma_addr_err` returns the block to run on the same edge.
- R4: A `sleep_req` sampled in run with control bit 0 set enters software standby. In that state `state_o`=2, all three clock enables are 0 and `refresh_mode`=1 (self-refresh). `pin_hiz` is 1 unless control bit 1 (`wr_sel`=0, `wr_data[1]`) is set, which holds the pin levels with `pin_hiz`=0.
- R5: In software standby, `irq` and `dma_addr_err` have no effect. An `nmi` moves the block to settling (`state_o`=3).
- R6: Settling lasts N = 8·2^min(c,9) cycles. Here c is the code written with `wr_sel`=3, `wr_data[3:0]`, and its reset value is 0. During settling `cpg_en`=1 and `core_clk_en`=0. `core_clk_en` returns to 1 exactly N edges after the edge that entered settling.
- R7: A low `hw_stby_n` at once forces all clock enables to 0, `pin_hiz` to 1 and `refresh_mode` to 2 (no refresh). `state_o` becomes 4 on the edge after the pin has passed the synchronizer, which is the third edge with the default two stages.
- R8: Hardware standby is left only through a power-on reset. Raising `hw_stby_n` while `por_n` is high keeps `state_o` at 4 with everything halted.
- R9: Module stop bits are written with `wr_sel`=1, one bit per module. A set bit drives that `mod_clk_en` bit to 0 while the core keeps running. Clearing the bit restarts the module. `mod_clk_en` is also 0 for every module whenever `periph_clk_en` is 0.
- R10: Module division bits are written with `wr_sel`=2. Each `mod_div_sel` bit follows its register bit, and writing 0 cancels the division.
- R11: A power-on reset clears every stop bit, every division bit, both control bits and the settle code, and returns the block to run.
- R12: A `sleep_req` sampled together with `irq`, `nmi` or `dma_addr_err` is dropped, and the block stays in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_stby_n | input | 1 | Hardware-standby pin, active low, asynchronous |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| irq | input | 1 | Enabled interrupt request |
| nmi | input | 1 | Non-maskable interrupt |
| dma_addr_err | input | 1 | DMA address-error flag |
| wr_en | input | 1 | Control write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 stop, 2 division, 3 settle code |
| wr_data | input | NUM_MOD | Write data |
| state_o | output | 3 | Current state code |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Common peripheral clock enable |
| cpg_en | output | 1 | Clock generator enable |
| pin_hiz | output | 1 | Pin tri-state request |
| refresh_mode | output | 2 | 0 normal, 1 self-refresh, 2 none |
| mod_clk_en | output | NUM_MOD | Per-module clock enable |
| mod_div_sel | output | NUM_MOD | Per-module extra division select |

## Verification
The hardest situation to reach is the sticky hardware standby. A pin that goes low and then high again must leave the block halted, and only a reset pulse while the pin is high may release it. The bench holds the pin low through the synchronizer delay and raises it with reset still released. It confirms that the state does not move for several cycles, then pulses reset. Long settling windows are a second hard case. They are reached by writing an out-of-range code, which must clamp to 4096 cycles, and counting edges until the core clock returns.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [2:0] {
      ST_RUN    = 3'd0,
      ST_SLEEP  = 3'd1,
      ST_SWSTBY = 3'd2,
      ST_SETTLE = 3'd3,
      ST_HWSTBY = 3'd4
   } lpm_state_e;

   localparam logic [1:0] REF_NORMAL = 2'd0;
   localparam logic [1:0] REF_SELF   = 2'd1;
   localparam logic [1:0] REF_OFF    = 2'd2;

   localparam logic [1:0] SEL_CTRL   = 2'd0;
   localparam logic [1:0] SEL_STOP   = 2'd1;
   localparam logic [1:0] SEL_DIV    = 2'd2;
   localparam logic [1:0] SEL_SETTLE = 2'd3;

   typedef struct packed {
      logic       core;
      logic       periph;
      logic       cpg;
      logic       hiz;
      logic [1:0] refresh;
   } lpm_ctl_s;
endpackage

// File: rtl/lpm_pin_sync.sv
module lpm_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic req
);
   generate
      if (STAGES == 0) begin : g_direct
         assign req = ~pin_n;
      end else begin : g_chain
         logic [STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else if (STAGES == 1) sync_q <= ~pin_n;
            else sync_q <= {sync_q[STAGES-2:0], ~pin_n};
         end
         assign req = sync_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lpm_cfg_regs.sv
module lpm_cfg_regs
   import lpm_pkg::*;
#(
   parameter int NUM_MOD  = 8,
   parameter int CODE_W   = 4,
   parameter int MAX_CODE = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [NUM_MOD-1:0] wr_data,
   output logic               stby_sel,
   output logic               pin_keep,
   output logic [NUM_MOD-1:0] stop_q,
   output logic [NUM_MOD-1:0] div_q,
   output logic [CODE_W-1:0]  code_q
);
   localparam logic [CODE_W-1:0] CODE_LIM = CODE_W'(MAX_CODE);

   logic [CODE_W-1:0] code_in;
   assign code_in = wr_data[CODE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stby_sel <= 1'b0;
         pin_keep <= 1'b0;
         stop_q   <= '0;
         div_q    <= '0;
         code_q   <= '0;
      end else if (wr_en) begin
         unique case (wr_sel)
            SEL_CTRL: begin
               stby_sel <= wr_data[0];
               pin_keep <= wr_data[1];
            end
            SEL_STOP:   stop_q <= wr_data;
            SEL_DIV:    div_q  <= wr_data;
            SEL_SETTLE: code_q <= (code_in > CODE_LIM) ? CODE_LIM : code_in;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
   parameter int CODE_W   = 4,
   parameter int MIN_LOG2 = 3,
   parameter int MAX_CODE = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] code,
   output logic              done
);
   localparam int CNT_W = MIN_LOG2 + MAX_CODE + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] span;

   assign span = CNT_W'(1) << (MIN_LOG2 + int'(code));
   assign done = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (load) cnt_q <= span - CNT_W'(1);
      else if (!done) cnt_q <= cnt_q - CNT_W'(1);
   end
endmodule

// File: rtl/lpm_state_fsm.sv
module lpm_state_fsm
   import lpm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stby_req,
   input  logic       sleep_req,
   input  logic       stby_sel,
   input  logic       irq,
   input  logic       nmi,
   input  logic       dma_addr_err,
   input  logic       settle_done,
   output logic       settle_start,
   output lpm_state_e state_q
);
   lpm_state_e state_d;
   logic       wake_any;

   assign wake_any     = irq | nmi | dma_addr_err;
   assign settle_start = (state_q == ST_SWSTBY) && nmi && !stby_req;

   always_comb begin
      state_d = state_q;
      if (stby_req) begin
         state_d = ST_HWSTBY;
      end else begin
         unique case (state_q)
            ST_RUN:
               if (sleep_req && !wake_any)
                  state_d = stby_sel ? ST_SWSTBY : ST_SLEEP;
            ST_SLEEP:
               if (wake_any) state_d = ST_RUN;
            ST_SWSTBY:
               if (nmi) state_d = ST_SETTLE;
            ST_SETTLE:
               if (settle_done) state_d = ST_RUN;
            ST_HWSTBY:
               state_d = ST_HWSTBY;
            default:
               state_d = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RUN;
      else state_q <= state_d;
   end
endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
   import lpm_pkg::*;
#(
   parameter int NUM_MOD     = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CODE_W      = 4,
   parameter int MIN_LOG2    = 3,
   parameter int MAX_CODE    = 9
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               hw_stby_n,
   input  logic               sleep_req,
   input  logic               irq,
   input  logic               nmi,
   input  logic               dma_addr_err,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [NUM_MOD-1:0] wr_data,
   output logic [2:0]         state_o,
   output logic               core_clk_en,
   output logic               periph_clk_en,
   output logic               cpg_en,
   output logic               pin_hiz,
   output logic [1:0]         refresh_mode,
   output logic [NUM_MOD-1:0] mod_clk_en,
   output logic [NUM_MOD-1:0] mod_div_sel
);
   initial begin
      if (NUM_MOD < CODE_W) $fatal(1, "NUM_MOD must cover the settle code field");
      if (CODE_W < 1 || MAX_CODE >= (1 << CODE_W)) $fatal(1, "MAX_CODE does not fit CODE_W");
      if (SYNC_STAGES < 0) $fatal(1, "SYNC_STAGES must be non-negative");
      if (MIN_LOG2 < 1) $fatal(1, "MIN_LOG2 must be at least 1");
   end

   logic               stby_req;
   logic               stby_sel;
   logic               pin_keep;
   logic [NUM_MOD-1:0] stop_q;
   logic [NUM_MOD-1:0] div_q;
   logic [CODE_W-1:0]  code_q;
   logic               settle_start;
   logic               settle_done;
   lpm_state_e         state_q;
   lpm_ctl_s           ctl;

   lpm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (por_n),
      .pin_n (hw_stby_n),
      .req   (stby_req)
   );

   lpm_cfg_regs #(.NUM_MOD(NUM_MOD), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_cfg (
      .clk      (clk),
      .rst_n    (por_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .stby_sel (stby_sel),
      .pin_keep (pin_keep),
      .stop_q   (stop_q),
      .div_q    (div_q),
      .code_q   (code_q)
   );

   lpm_settle_timer #(.CODE_W(CODE_W), .MIN_LOG2(MIN_LOG2), .MAX_CODE(MAX_CODE)) u_timer (
      .clk   (clk),
      .rst_n (por_n),
      .load  (settle_start),
      .code  (code_q),
      .done  (settle_done)
   );

   lpm_state_fsm u_fsm (
      .clk          (clk),
      .rst_n        (por_n),
      .stby_req     (stby_req),
      .sleep_req    (sleep_req),
      .stby_sel     (stby_sel),
      .irq          (irq),
      .nmi          (nmi),
      .dma_addr_err (dma_addr_err),
      .settle_done  (settle_done),
      .settle_start (settle_start),
      .state_q      (state_q)
   );

   always_comb begin
      ctl = '{core: 1'b1, periph: 1'b1, cpg: 1'b1, hiz: 1'b0, refresh: REF_NORMAL};
      unique case (state_q)
         ST_RUN: ;
         ST_SLEEP:  ctl.core = 1'b0;
         ST_SWSTBY: ctl = '{core: 1'b0, periph: 1'b0, cpg: 1'b0,
                            hiz: !pin_keep, refresh: REF_SELF};
         ST_SETTLE: ctl = '{core: 1'b0, periph: 1'b0, cpg: 1'b1,
                            hiz: !pin_keep, refresh: REF_SELF};
         ST_HWSTBY: ctl = '{core: 1'b0, periph: 1'b0, cpg: 1'b0,
                            hiz: 1'b1, refresh: REF_OFF};
         default: ;
      endcase
      if (!hw_stby_n)
         ctl = '{core: 1'b0, periph: 1'b0, cpg: 1'b0, hiz: 1'b1, refresh: REF_OFF};
   end

   assign state_o       = state_q;
   assign core_clk_en   = ctl.core;
   assign periph_clk_en = ctl.periph;
   assign cpg_en        = ctl.cpg;
   assign pin_hiz       = ctl.hiz;
   assign refresh_mode  = ctl.refresh;

   generate
      for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
         assign mod_clk_en[m]  = ctl.periph & ~stop_q[m];
         assign mod_div_sel[m] = div_q[m];
      end
   endgenerate
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
   parameter int NUM_MOD = 8
) (
   input logic               clk,
   input logic               por_n,
   input logic               hw_stby_n,
   input logic               stby_req,
   input logic               sleep_req,
   input logic               irq,
   input logic               nmi,
   input logic               dma_addr_err,
   input logic [2:0]         state_o,
   input logic               core_clk_en,
   input logic               periph_clk_en,
   input logic               cpg_en,
   input logic               pin_hiz,
   input logic [1:0]         refresh_mode,
   input logic [NUM_MOD-1:0] mod_clk_en
);
   p_sleep_wake_r3: assert property (@(posedge clk) disable iff (!por_n)
      (state_o == 3'd1 && (irq || nmi || dma_addr_err) && !stby_req) |=> state_o == 3'd0)
      else $error("p_sleep_wake_r3");

   p_swstby_ignore_r5: assert property (@(posedge clk) disable iff (!por_n)
      (state_o == 3'd2 && !nmi && !stby_req) |=> state_o == 3'd2)
      else $error("p_swstby_ignore_r5");

   p_settle_core_off_r6: assert property (@(posedge clk) disable iff (!por_n)
      (state_o == 3'd3) |-> (!core_clk_en && cpg_en))
      else $error("p_settle_core_off_r6");

   p_hw_halt_r7: assert property (@(posedge clk) disable iff (!por_n)
      (!hw_stby_n) |-> (!core_clk_en && !periph_clk_en && !cpg_en && pin_hiz && refresh_mode == 2'd2))
      else $error("p_hw_halt_r7");

   p_hw_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
      (state_o == 3'd4) |=> state_o == 3'd4)
      else $error("p_hw_sticky_r8");

   p_mod_off_r9: assert property (@(posedge clk) disable iff (!por_n)
      (!periph_clk_en) |-> (mod_clk_en == '0))
      else $error("p_mod_off_r9");

   p_same_cycle_r12: assert property (@(posedge clk) disable iff (!por_n)
      (state_o == 3'd0 && sleep_req && (irq || nmi || dma_addr_err) && !stby_req) |=> state_o == 3'd0)
      else $error("p_same_cycle_r12");
endmodule

bind lpm_seq_ctrl lpm_seq_chk #(.NUM_MOD(NUM_MOD)) chk_i (
   .clk           (clk),
   .por_n         (por_n),
   .hw_stby_n     (hw_stby_n),
   .stby_req      (stby_req),
   .sleep_req     (sleep_req),
   .irq           (irq),
   .nmi           (nmi),
   .dma_addr_err  (dma_addr_err),
   .state_o       (state_o),
   .core_clk_en   (core_clk_en),
   .periph_clk_en (periph_clk_en),
   .cpg_en        (cpg_en),
   .pin_hiz       (pin_hiz),
   .refresh_mode  (refresh_mode),
   .mod_clk_en    (mod_clk_en)
);

// File: tb/lpm_seq_ctrl_tb_top.sv
module lpm_seq_ctrl_tb_top;
   localparam int NM = 8;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          hw_stby_n = 1'b1;
   logic          sleep_req = 1'b0;
   logic          irq = 1'b0;
   logic          nmi = 1'b0;
   logic          dma_addr_err = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = '0;
   logic [NM-1:0] wr_data = '0;
   logic [2:0]    state_o;
   logic          core_clk_en, periph_clk_en, cpg_en, pin_hiz;
   logic [1:0]    refresh_mode;
   logic [NM-1:0] mod_clk_en, mod_div_sel;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lpm_seq_ctrl #(.NUM_MOD(NM)) dut_i (
      .clk(clk), .por_n(por_n), .hw_stby_n(hw_stby_n), .sleep_req(sleep_req),
      .irq(irq), .nmi(nmi), .dma_addr_err(dma_addr_err), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .state_o(state_o),
      .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .cpg_en(cpg_en),
      .pin_hiz(pin_hiz), .refresh_mode(refresh_mode), .mod_clk_en(mod_clk_en),
      .mod_div_sel(mod_div_sel)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // packs {state, core, periph, cpg, hiz, refresh}
   function automatic logic [31:0] snap();
      return {24'd0, state_o, core_clk_en, periph_clk_en, cpg_en, pin_hiz, refresh_mode} >> 0;
   endfunction

   function automatic logic [31:0] mk(input int st, input bit c, p, g, h, input int rf);
      return {24'd0, 3'(st), c, p, g, h, 2'(rf)};
   endfunction

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      @(negedge clk); por_n = 1'b0;
      tick();
      @(negedge clk); por_n = 1'b1;
      tick();
   endtask

   task automatic write(input logic [1:0] sel, input logic [NM-1:0] d);
      @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
      tick();
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pulse_sleep();
      @(negedge clk); sleep_req = 1'b1;
      tick();
      @(negedge clk); sleep_req = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk); por_n = 1'b0; #1;
      check("R1 state during reset", snap(), mk(0, 1, 1, 1, 0, 0));
      @(negedge clk); por_n = 1'b1;
      tick();
      check("R1 state after reset", snap(), mk(0, 1, 1, 1, 0, 0));
      check("R1 mod_clk_en", 32'(mod_clk_en), 32'hFF);
      check("R1 mod_div_sel", 32'(mod_div_sel), 32'h0);
   endtask

   task automatic t_sleep(input int src);
      do_reset();
      pulse_sleep();
      check("R2 sleep entry", snap(), mk(1, 0, 1, 1, 0, 0));
      @(negedge clk);
      irq = (src == 0); nmi = (src == 1); dma_addr_err = (src == 2);
      tick();
      check($sformatf("R3 sleep wake source %0d", src), 32'(state_o), 32'd0);
      check("R3 core clock back", 32'(core_clk_en), 32'd1);
      @(negedge clk); irq = 0; nmi = 0; dma_addr_err = 0;
   endtask

   task automatic t_same_cycle();
      do_reset();
      @(negedge clk); sleep_req = 1'b1; dma_addr_err = 1'b1;
      tick();
      check("R12 sleep with dma error dropped", 32'(state_o), 32'd0);
      @(negedge clk); dma_addr_err = 1'b0; irq = 1'b1;
      tick();
      check("R12 sleep with irq dropped", 32'(state_o), 32'd0);
      @(negedge clk); sleep_req = 1'b0; irq = 1'b0;
   endtask

   task automatic t_swstby(input bit keep);
      do_reset();
      write(2'd0, {6'd0, keep, 1'b1});
      pulse_sleep();
      check($sformatf("R4 software standby keep=%0d", keep), snap(), mk(2, 0, 0, 0, !keep, 1));
      @(negedge clk); irq = 1'b1; dma_addr_err = 1'b1;
      tick(); tick();
      check("R5 irq/dma ignored in standby", snap(), mk(2, 0, 0, 0, !keep, 1));
      @(negedge clk); irq = 1'b0; dma_addr_err = 1'b0; nmi = 1'b1;
      tick();
      check("R5 nmi enters settling", 32'(state_o), 32'd3);
      @(negedge clk); nmi = 1'b0;
   endtask

   task automatic t_settle(input logic [3:0] code, input int expn);
      int n;
      do_reset();
      write(2'd3, {4'd0, code});
      write(2'd0, 8'h01);
      pulse_sleep();
      @(negedge clk); nmi = 1'b1;
      tick();
      @(negedge clk); nmi = 1'b0;
      check("R6 settling holds core off", {30'd0, core_clk_en, cpg_en}, 32'd1);
      n = 0;
      while (!core_clk_en && n < 6000) begin
         tick(); n++;
      end
      check($sformatf("R6 settle length code %0d", code), 32'(n), 32'(expn));
      check("R6 back in run", 32'(state_o), 32'd0);
   endtask

   task automatic t_hwstby();
      do_reset();
      pulse_sleep();
      @(negedge clk); hw_stby_n = 1'b0; #1;
      check("R7 immediate halt", {29'd0, core_clk_en, periph_clk_en, cpg_en, pin_hiz, refresh_mode} >> 0,
            {29'd0, 3'b000, 1'b1, 2'd2} >> 0);
      tick(); tick();
      check("R7 state before sync done", 32'(state_o), 32'd1);
      tick();
      check("R7 state hardware standby", 32'(state_o), 32'd4);
      @(negedge clk); hw_stby_n = 1'b1;
      for (int i = 0; i < 5; i++) tick();
      check("R8 stays after pin release", snap(), mk(4, 0, 0, 0, 1, 2));
      @(negedge clk); irq = 1'b1; nmi = 1'b1;
      tick();
      check("R8 wake events ignored", 32'(state_o), 32'd4);
      @(negedge clk); irq = 1'b0; nmi = 1'b0;
      do_reset();
      check("R8 reset releases", snap(), mk(0, 1, 1, 1, 0, 0));
   endtask

   task automatic t_modules();
      do_reset();
      write(2'd1, 8'hA5);
      tick();
      check("R9 stopped modules", 32'(mod_clk_en), 32'h5A);
      check("R9 core keeps running", 32'(core_clk_en), 32'd1);
      pulse_sleep();
      check("R9 sleep keeps module pattern", 32'(mod_clk_en), 32'h5A);
      @(negedge clk); irq = 1'b1; tick(); @(negedge clk); irq = 1'b0;
      write(2'd1, 8'h00);
      tick();
      check("R9 cleared stop restarts", 32'(mod_clk_en), 32'hFF);
      write(2'd0, 8'h01);
      pulse_sleep();
      check("R9 standby gates all modules", 32'(mod_clk_en), 32'h00);
      write(2'd2, 8'h3C);
      tick();
      check("R10 division select", 32'(mod_div_sel), 32'h3C);
      write(2'd2, 8'h00);
      tick();
      check("R10 division cancelled", 32'(mod_div_sel), 32'h00);
   endtask

   task automatic t_por_clear();
      do_reset();
      write(2'd1, 8'hFF);
      write(2'd2, 8'hFF);
      write(2'd0, 8'h03);
      do_reset();
      check("R11 stop bits cleared", 32'(mod_clk_en), 32'hFF);
      check("R11 div bits cleared", 32'(mod_div_sel), 32'h00);
      pulse_sleep();
      check("R11 select cleared gives sleep", 32'(state_o), 32'd1);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_sleep(0);
      t_sleep(1);
      t_sleep(2);
      t_same_cycle();
      t_swstby(1'b0);
      t_swstby(1'b1);
      t_settle(4'd0, 8);
      t_settle(4'd2, 32);
      t_settle(4'd15, 4096);
      t_hwstby();
      t_modules();
      t_por_clear();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule